// File: doc/BRIEF.md
# Precision-reconfigurable tile multiplier

This block forms products of small unsigned matrix tiles on a fixed fabric of sixteen 4x4-bit multipliers. The fabric is 16 bits on a side. A two-bit precision code picks the item width b (4, 8 or 16 bits), and the tile edge becomes h = 16/b. Every supported width is assembled from the same 4x4 partial products: a 16-bit item uses all sixteen, an 8-bit item uses four, and a 4-bit item uses one.

A driver cuts a large matrix product into tile pairs and streams them in over a valid/ready handshake. Each tile pair is processed as h outer-product passes, with one pass per clock. Each pass keeps the whole multiplier array busy. Partial products are combined by chained three-operand adders and added into one accumulator per result item. A last flag on the input closes a reduction. The finished tile is then held on the output until the consumer takes it, and the accumulators start again from zero.

The precision code is taken only when nothing is in flight and no reduction is open.

Top module: `mm_tile_engine`

## Requirements
- R1: The precision code selects the item width. Code 0 gives 4-bit items in 4x4 tiles, code 1 gives 8-bit items in 2x2 tiles, and codes 2 and 3 both give 16-bit items in 1x1 tiles.
- R2: Input item (r,c) of an h x h tile sits in `x_tile`/`y_tile` bits [(r*h+c)*b +: b]. Bits at or above h*h*b have no effect on the result.
- R3: Result item (r,c) is the sum, over every tile pair of a reduction, of sum over k of X[r][k]*Y[k][c]. Items are unsigned and the sum wraps modulo 2^(2b+8). The item appears zero-extended in `out_tile` bits [(r*h+c)*40 +: 40], and all other 40-bit slots read zero.
- R4: While the output is not stalled, the block accepts consecutive tile pairs exactly h clock cycles apart.
- R5: With nothing else in flight and `out_ready` high, `out_valid` rises h+1 rising edges after the edge that accepts a last-flagged tile pair.
- R6: While `out_valid` is high and `out_ready` is low, `out_tile` stays unchanged and `in_ready` stays low. `out_valid` drops only after an edge at which `out_ready` was high.
- R7: After a result is taken, the next reduction starts from zero in every accumulator.
- R8: A change of the precision code while a reduction is open or a tile is in flight has no effect on that reduction.
- R9: During reset and just after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prec | input | 2 | Precision code (R1) |
| in_valid | input | 1 | Tile pair offered |
| in_ready | output | 1 | Tile pair taken on this edge if offered |
| in_last | input | 1 | Offered tile pair closes the reduction |
| x_tile | input | 64 | Left tile, packed row-major |
| y_tile | input | 64 | Right tile, packed row-major |
| out_valid | output | 1 | Result tile presented |
| out_ready | input | 1 | Consumer takes the result |
| out_tile | output | 640 | Sixteen 40-bit result slots |

## Verification
A wrong digit route in the switch, or a wrong shift in the reducer, corrupts particular result slots. The error shows up in the first result tile of the affected precision, h+1 edges after its last input. A pass counter that stops early or late changes both the tile spacing on `in_ready` and every result of that width. An accumulator that fails to clear shows up only in the second reduction, as the first reduction's sum added in. A precision register that moves mid-reduction shows up as a result computed at the wrong width when the reduction closes.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef logic [1:0] expo_t;

  typedef struct packed {
    logic vld;
    logic fin;
  } stage_tag_t;

  function automatic int dig_per_item(input int expo);
    return 1 << expo;
  endfunction

  function automatic int tile_dim(input int arr_dig, input int expo);
    return arr_dig >> expo;
  endfunction

  function automatic int clamp_expo(input int code, input int max_e);
    return (code > max_e) ? max_e : code;
  endfunction
endpackage

// File: rtl/mm_operand_switch.sv
module mm_operand_switch
  import mm_pkg::*;
#(
  parameter int ARR_W = 16,
  parameter int DIG_W = 4,
  localparam int ARR_DIG = ARR_W / DIG_W,
  localparam int NUM_MUL = ARR_DIG * ARR_DIG,
  localparam int BUS_W = ARR_W * ARR_W / DIG_W,
  localparam int CW = (ARR_DIG > 1) ? $clog2(ARR_DIG) : 1,
  localparam int MAX_E = (ARR_DIG > 1) ? $clog2(ARR_DIG) : 0
) (
  input  logic [BUS_W-1:0]              x_tile,
  input  logic [BUS_W-1:0]              y_tile,
  input  expo_t                         expo,
  input  logic [CW-1:0]                 pass,
  output logic [NUM_MUL-1:0][DIG_W-1:0] x_dig,
  output logic [NUM_MUL-1:0][DIG_W-1:0] y_dig
);
  // Route one digit of X[row][pass] and one of Y[pass][col] to each multiplier.
  always_comb begin
    int e, nd, dim, bw, pi, item, di, dj, row, col;
    e   = clamp_expo(int'(expo), MAX_E);
    nd  = dig_per_item(e);
    dim = tile_dim(ARR_DIG, e);
    bw  = DIG_W * nd;
    pi  = int'(pass);
    for (int k = 0; k < NUM_MUL; k++) begin
      item = k / (nd * nd);
      di   = (k / nd) % nd;
      dj   = k % nd;
      row  = item / dim;
      col  = item % dim;
      x_dig[k] = x_tile[(row * dim + pi) * bw + DIG_W * di +: DIG_W];
      y_dig[k] = y_tile[(pi * dim + col) * bw + DIG_W * dj +: DIG_W];
    end
  end
endmodule

// File: rtl/mm_pp_array.sv
module mm_pp_array #(
  parameter int DIG_W = 4,
  parameter int NUM_MUL = 16,
  localparam int PP_W = 2 * DIG_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [NUM_MUL-1:0][DIG_W-1:0] x_dig,
  input  logic [NUM_MUL-1:0][DIG_W-1:0] y_dig,
  output logic [NUM_MUL-1:0][PP_W-1:0]  pp_q
);
  logic [PP_W-1:0] pp_d [NUM_MUL];

  for (genvar k = 0; k < NUM_MUL; k++) begin : g_mul
    assign pp_d[k] = PP_W'(x_dig[k]) * PP_W'(y_dig[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp_q <= '0;
    end else if (en) begin
      for (int k = 0; k < NUM_MUL; k++) pp_q[k] <= pp_d[k];
    end
  end
endmodule

// File: rtl/mm_reduce_acc.sv
module mm_reduce_acc
  import mm_pkg::*;
#(
  parameter int ARR_W = 16,
  parameter int DIG_W = 4,
  localparam int ARR_DIG = ARR_W / DIG_W,
  localparam int NUM_MUL = ARR_DIG * ARR_DIG,
  localparam int PP_W = 2 * DIG_W,
  localparam int ACC_W = 2 * ARR_W + 8,
  localparam int MAX_E = (ARR_DIG > 1) ? $clog2(ARR_DIG) : 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  expo_t                         expo,
  input  logic                          acc_en,
  input  logic                          acc_clr,
  input  logic [NUM_MUL-1:0][PP_W-1:0]  pp,
  output logic [NUM_MUL-1:0][ACC_W-1:0] acc_q
);
  logic [NUM_MUL-1:0][ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] wrap_mask;

  function automatic logic [ACC_W-1:0] add3(input logic [ACC_W-1:0] a,
                                            input logic [ACC_W-1:0] b,
                                            input logic [ACC_W-1:0] c);
    return a + b + c;
  endfunction

  always_comb begin
    int e, nd, nn, nslot;
    logic [ACC_W-1:0] sum, op0, op1;
    e     = clamp_expo(int'(expo), MAX_E);
    nd    = dig_per_item(e);
    nn    = nd * nd;
    nslot = NUM_MUL / nn;
    for (int i = 0; i < ACC_W; i++) wrap_mask[i] = (i < 2 * DIG_W * nd + 8);
    for (int q = 0; q < NUM_MUL; q++) begin
      sum = '0;
      for (int t = 0; t < NUM_MUL; t += 2) begin
        op0 = '0;
        op1 = '0;
        if (q < nslot && t < nn) begin
          op0 = ACC_W'(pp[q * nn + t]) << (DIG_W * (t / nd + t % nd));
          if (t + 1 < nn)
            op1 = ACC_W'(pp[q * nn + t + 1]) << (DIG_W * ((t + 1) / nd + (t + 1) % nd));
        end
        sum = add3(sum, op0, op1);
      end
      acc_d[q] = ((acc_clr ? '0 : acc_q[q]) + (acc_en ? (sum & wrap_mask) : '0)) & wrap_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en || acc_clr) begin
      acc_q <= acc_d;
    end
  end

  // R3: slots beyond the tile stay empty at wider precisions
  assert_unused_slot_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (expo != '0) |-> (acc_q[NUM_MUL-1] == '0));

  // R8: precision seen by the reducer never moves under an accumulation
  assert_prec_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> $stable(expo));
endmodule

// File: rtl/mm_tile_engine.sv
module mm_tile_engine
  import mm_pkg::*;
#(
  parameter int ARR_W = 16,
  parameter int DIG_W = 4,
  localparam int ARR_DIG = ARR_W / DIG_W,
  localparam int NUM_MUL = ARR_DIG * ARR_DIG,
  localparam int BUS_W = ARR_W * ARR_W / DIG_W,
  localparam int PP_W = 2 * DIG_W,
  localparam int ACC_W = 2 * ARR_W + 8,
  localparam int OUT_W = NUM_MUL * ACC_W,
  localparam int CW = (ARR_DIG > 1) ? $clog2(ARR_DIG) : 1,
  localparam int MAX_E = (ARR_DIG > 1) ? $clog2(ARR_DIG) : 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       prec,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_last,
  input  logic [BUS_W-1:0] x_tile,
  input  logic [BUS_W-1:0] y_tile,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_tile
);
  logic [1:0] rst_pipe;
  logic rst_core_n;
  logic busy_q, busy_d, last_q, last_d, open_q, open_d, out_vld_q, out_vld_d;
  logic [CW-1:0] pass_q, pass_d, pass_max;
  logic [BUS_W-1:0] xt_q, yt_q;
  expo_t e_q, e_d, e_in;
  stage_tag_t s1_q, s1_d;
  logic idle, hold, accept, adv, pass_end, acc_en, acc_clr;
  logic [NUM_MUL-1:0][DIG_W-1:0] x_dig, y_dig;
  logic [NUM_MUL-1:0][PP_W-1:0] pp_q;
  logic [NUM_MUL-1:0][ACC_W-1:0] acc_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign e_in     = expo_t'(clamp_expo(int'(prec), MAX_E));
  assign idle     = !busy_q && !s1_q.vld && !out_vld_q && !open_q;
  assign hold     = out_vld_q && !out_ready;
  assign pass_max = CW'(tile_dim(ARR_DIG, int'(e_q)) - 1);
  assign pass_end = (pass_q == pass_max);
  assign in_ready = !hold && (!busy_q || pass_end);
  assign accept   = in_valid && in_ready;
  assign adv      = busy_q && !hold;
  assign acc_en   = s1_q.vld && !hold;
  assign acc_clr  = out_vld_q && out_ready;

  always_comb begin
    busy_d = busy_q;
    pass_d = pass_q;
    last_d = last_q;
    open_d = open_q;
    e_d    = idle ? e_in : e_q;
    if (accept) begin
      busy_d = 1'b1;
      pass_d = '0;
      last_d = in_last;
      open_d = !in_last;
    end else if (adv) begin
      if (pass_end) busy_d = 1'b0;
      else          pass_d = pass_q + 1'b1;
    end
    s1_d = s1_q;
    if (!hold) begin
      s1_d.vld = busy_q;
      s1_d.fin = busy_q && last_q && pass_end;
    end
    out_vld_d = out_vld_q;
    if (acc_en && s1_q.fin) out_vld_d = 1'b1;
    else if (acc_clr)       out_vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      busy_q    <= 1'b0;
      pass_q    <= '0;
      last_q    <= 1'b0;
      open_q    <= 1'b0;
      e_q       <= '0;
      s1_q      <= '0;
      out_vld_q <= 1'b0;
      xt_q      <= '0;
      yt_q      <= '0;
    end else begin
      busy_q    <= busy_d;
      pass_q    <= pass_d;
      last_q    <= last_d;
      open_q    <= open_d;
      e_q       <= e_d;
      s1_q      <= s1_d;
      out_vld_q <= out_vld_d;
      if (accept) begin
        xt_q <= x_tile;
        yt_q <= y_tile;
      end
    end
  end

  mm_operand_switch #(.ARR_W(ARR_W), .DIG_W(DIG_W)) u_switch (
    .x_tile(xt_q), .y_tile(yt_q), .expo(e_q), .pass(pass_q),
    .x_dig(x_dig), .y_dig(y_dig)
  );

  mm_pp_array #(.DIG_W(DIG_W), .NUM_MUL(NUM_MUL)) u_pp (
    .clk(clk), .rst_n(rst_core_n), .en(adv),
    .x_dig(x_dig), .y_dig(y_dig), .pp_q(pp_q)
  );

  mm_reduce_acc #(.ARR_W(ARR_W), .DIG_W(DIG_W)) u_acc (
    .clk(clk), .rst_n(rst_core_n), .expo(e_q), .acc_en(acc_en),
    .acc_clr(acc_clr), .pp(pp_q), .acc_q(acc_q)
  );

  assign out_valid = out_vld_q;
  assign out_tile  = acc_q;

  // R6: a presented result is frozen until taken
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_vld_q && !out_ready) |=> (out_vld_q && $stable(out_tile)));

  // R6: the result is withdrawn only after a handshake
  assert_out_drop_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(out_vld_q) |-> $past(out_ready));

  // R4: pass counter never runs past the tile edge
  assert_pass_range_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy_q |-> (pass_q <= pass_max));

  // R5: a result appears only after the closing pass was accumulated
  assert_out_source_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(out_vld_q) |-> $past(s1_q.fin));
endmodule

// File: tb/sim_mm_tile_engine.sv
module sim_mm_tile_engine;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] prec = '0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [63:0] x_tile = '0, y_tile = '0;
  logic in_ready, out_valid;
  logic [639:0] out_tile;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [63:0] xs [128];
  logic [63:0] ys [128];
  time acc_t [128];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mm_tile_engine u0 (
    .clk(clk), .rst_n(rst_n), .prec(prec), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .x_tile(x_tile), .y_tile(y_tile), .out_valid(out_valid),
    .out_ready(out_ready), .out_tile(out_tile)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid in reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R9", "in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  // one reduction: build tiles, predict, stream, take and compare
  task automatic run_reduce(input string req, input int code, input int ntiles, input int pattern,
                            input int out_stall, input int flip_code, input bit check_rate);
    int e = (code > 2) ? 2 : code;
    int b = 4 << e;
    int h = 4 >> e;
    int aw = 2 * b + 8;
    logic [63:0] expv [16];
    logic [63:0] mask = (64'd1 << aw) - 1;
    logic [63:0] imask = (64'd1 << b) - 1;
    for (int q = 0; q < 16; q++) expv[q] = '0;
    for (int t = 0; t < ntiles; t++) begin
      xs[t] = (pattern == 1) ? '1 : {$urandom, $urandom};
      ys[t] = (pattern == 1) ? '1 : {$urandom, $urandom};
      for (int r = 0; r < h; r++)
        for (int c = 0; c < h; c++)
          for (int k = 0; k < h; k++)
            expv[r*h+c] = (expv[r*h+c] + ((xs[t] >> ((r*h+k)*b)) & imask)
                                       * ((ys[t] >> ((k*h+c)*b)) & imask)) & mask;
    end
    @(negedge clk);
    prec = 2'(code);
    fork
      begin : producer
        for (int t = 0; t < ntiles; t++) begin
          in_valid = 1'b1;
          x_tile = xs[t];
          y_tile = ys[t];
          in_last = (t == ntiles - 1);
          #1;
          while (!in_ready) begin @(negedge clk); #1; end
          @(posedge clk);
          acc_t[t] = $time;
          #1;
          if (t == 0 && flip_code >= 0) prec = 2'(flip_code);
          if (t == ntiles - 1) begin in_valid = 1'b0; in_last = 1'b0; end
          else @(negedge clk);
        end
      end
      begin : consumer
        logic [639:0] held;
        logic [63:0] a_v, e_v;
        bit ok;
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        held = out_tile;
        for (int s = 0; s < out_stall; s++) begin
          check(in_ready == 1'b0, "R6", "in_ready while result waits", 64'(in_ready), 64'd0);
          @(negedge clk);
          check(out_valid && out_tile == held, "R6", "result held under stall",
                64'(out_valid), 64'd1);
        end
        out_ready = 1'b1;
        ok = 1'b1; a_v = '0; e_v = '0;
        for (int q = 0; q < 16; q++) begin
          logic [63:0] want = (q < h * h) ? expv[q] : 64'd0;
          logic [63:0] got = 64'(out_tile[q*SLOT_W +: SLOT_W]);
          if (ok && got != want) begin ok = 1'b0; a_v = got; e_v = want; end
        end
        check(ok, req, "result tile slot", a_v, e_v);
        @(posedge clk);
        #1;
        out_ready = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R6", "out_valid after take", 64'(out_valid), 64'd0);
      end
    join
    if (check_rate && ntiles > 1) begin
      bit rok = 1'b1;
      logic [63:0] gap = '0;
      for (int t = 1; t < ntiles; t++)
        if (rok && (acc_t[t] - acc_t[t-1]) != time'(h * CLK_PERIOD)) begin
          rok = 1'b0;
          gap = 64'(acc_t[t] - acc_t[t-1]);
        end
      check(rok, "R4", "tile acceptance spacing", gap, 64'(h * CLK_PERIOD));
    end
  endtask

  // R5: edges from the closing accept to out_valid
  task automatic check_latency(input int code);
    int h = 4 >> code;
    int n = 0;
    @(negedge clk);
    prec = 2'(code);
    in_valid = 1'b1; in_last = 1'b1;
    x_tile = {$urandom, $urandom}; y_tile = {$urandom, $urandom};
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    while (!out_valid && n < 20) begin @(negedge clk); n++; end
    check(n == h + 1, "R5", "edges to out_valid", 64'(n), 64'(h + 1));
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    out_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    check_reset();
    run_reduce("R1 R2 R3 4-bit single", 0, 1, 0, 0, -1, 1'b0);
    run_reduce("R1 R2 R3 8-bit single", 1, 1, 0, 0, -1, 1'b0);
    run_reduce("R1 R2 R3 16-bit single", 2, 1, 0, 0, -1, 1'b0);
    run_reduce("R1 code3 as 16-bit", 3, 1, 0, 0, -1, 1'b0);
    run_reduce("R3 R4 4-bit chain", 0, 6, 0, 0, -1, 1'b1);
    run_reduce("R3 R4 8-bit chain", 1, 5, 0, 0, -1, 1'b1);
    run_reduce("R3 R4 16-bit chain", 2, 7, 0, 0, -1, 1'b1);
    run_reduce("R3 wrap 4-bit", 0, 80, 1, 0, -1, 1'b0);
    run_reduce("R6 stalled 8-bit", 1, 3, 0, 4, -1, 1'b0);
    run_reduce("R7 fresh after stall", 1, 2, 0, 0, -1, 1'b0);
    run_reduce("R8 flip 8-bit to 4-bit", 1, 4, 0, 2, 0, 1'b0);
    run_reduce("R8 flip 4-bit to 16-bit", 0, 3, 0, 0, 2, 1'b0);
    run_reduce("R7 fresh 16-bit wrap", 2, 3, 1, 0, -1, 1'b0);
    check_latency(0);
    check_latency(1);
    check_latency(2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule